// File: doc/BRIEF.md
# Message Pending Register Bank

This block keeps a bank of 32-bit pending registers for a controller that handles many message objects. When a message object reports a receive or transmit event, the block works out which register and which bit to flag, and sets that bit. It has two placement modes. In the default mode the object's 8-bit pending number alone picks the register and the bit. In the split mode the object's receive or transmit node pointer picks the register and the half-word. This lets one object flag different registers depending on the direction of the event.

Software reaches the bank through a simple synchronous register port. A write clears each bit that is written as 0 and keeps each bit that is written as 1. Software can therefore clear single bits without a read-modify-write sequence. A bit that hardware sets in the same cycle as such a write is never lost.

Each pending register has a read-only index register beside it. The index register always shows the lowest set bit position of its pending register, or 32 when that register is empty. The index follows every change in the same cycle as the change.

Top module: `msg_pend_bank`

## Requirements
- R1: After reset all eight pending registers read 0 and all eight index registers read 32.
- R2: With mode 4'b0000, an accepted event sets bit pnum[4:0] of register pnum[7:5].
- R3: With mode 4'b1111 and ev_is_tx=1, the event sets register tx_np[3:1], at bit position {tx_np[0], pnum[3:0]}.
- R4: With mode 4'b1111 and ev_is_tx=0, the event sets register rx_np[3:1], at bit position {rx_np[0], pnum[3:0]}.
- R5: Any mode value other than 4'b0000 and 4'b1111 places bits exactly as mode 4'b0000 does.
- R6: A software write to pending register k (sw_addr[3]=0, sw_addr[2:0]=k) computes the new value as old AND sw_wdata. Bits written 0 clear and bits written 1 keep their value.
- R7: When an event sets a bit in the same cycle as a software write to that register, the set bit ends at 1, even if the write carried 0 there. The other bits follow R6.
- R8: Reading sw_addr[3]=1, sw_addr[2:0]=k returns the lowest set bit position of pending register k, or 32 if that register is 0. The value already reflects the edge that changed the register.
- R9: Writes to the index addresses (sw_addr[3]=1) change no pending register.
- R10: With ev_valid=0, the pending registers change only through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Placement mode field (4'b1111 = split, other values = default) |
| ev_valid | input | 1 | Event strobe, at most one event per cycle |
| ev_is_tx | input | 1 | 1 = transmit event, 0 = receive event |
| ev_pnum | input | 8 | Pending number of the message object |
| ev_rx_np | input | 4 | Receive node pointer of the object |
| ev_tx_np | input | 4 | Transmit node pointer of the object |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 4 | [3]=0 pending register, [3]=1 index register; [2:0] register number |
| sw_wdata | input | 32 | Write data, used as a keep mask |
| sw_rdata | output | 32 | Read data, combinational from sw_addr |

## Verification
A hardware set and a software write-zero clear can land on the same register in the same clock edge. This matters most when both target the same bit. The bench provokes this in a directed case: it sets one bit while writing all zeros to that register. In the random phase it aims writes at the register the event selects with high probability. A bench model computes old AND mask, OR the new bit, and the bench compares that value and the index readback after every edge.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam logic [3:0] MODE_DEFAULT = 4'b0000;
  localparam logic [3:0] MODE_SPLIT   = 4'b1111;

  typedef enum logic {
    BANK_PEND  = 1'b0,
    BANK_INDEX = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/mpb_locate.sv
module mpb_locate #(
  parameter int RSEL_W = 3,
  parameter int BIT_W  = 5,
  localparam int PN_W  = RSEL_W + BIT_W,
  localparam int NP_W  = RSEL_W + 1
) (
  input  logic [3:0]        mode,
  input  logic              is_tx,
  input  logic [PN_W-1:0]   pnum,
  input  logic [NP_W-1:0]   rx_np,
  input  logic [NP_W-1:0]   tx_np,
  output logic [RSEL_W-1:0] reg_sel,
  output logic [BIT_W-1:0]  bit_pos
);
  import mpb_pkg::*;

  function automatic logic [RSEL_W+BIT_W-1:0] place(
    input logic [3:0]      m,
    input logic            tx,
    input logic [PN_W-1:0] pn,
    input logic [NP_W-1:0] rnp,
    input logic [NP_W-1:0] tnp
  );
    logic [NP_W-1:0] np;
    np = tx ? tnp : rnp;
    if (m == MODE_SPLIT)
      place = {np[NP_W-1:1], np[0], pn[BIT_W-2:0]};
    else
      place = pn;
  endfunction

  assign {reg_sel, bit_pos} = place(mode, is_tx, pnum, rx_np, tx_np);
endmodule

// File: rtl/mpb_lsb_index.sv
module mpb_lsb_index #(
  parameter int REG_W = 32,
  localparam int IDX_W = $clog2(REG_W) + 1
) (
  input  logic [REG_W-1:0] vec,
  output logic [IDX_W-1:0] idx
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [REG_W-1:0] v);
    lowest_set = IDX_W'(REG_W);
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = IDX_W'(i);
    end
  endfunction

  assign idx = lowest_set(vec);
endmodule

// File: rtl/mpb_pend_reg.sv
module mpb_pend_reg #(
  parameter int REG_W = 32,
  localparam int BIT_W = $clog2(REG_W),
  localparam int IDX_W = BIT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_hit,
  input  logic [BIT_W-1:0] set_bit,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_keep,
  output logic [REG_W-1:0] pend_q,
  output logic [IDX_W-1:0] idx
);
  logic [REG_W-1:0] set_mask;
  logic [REG_W-1:0] keep_mask;
  logic [REG_W-1:0] pend_d;

  assign set_mask  = set_hit ? (REG_W'(1) << set_bit) : '0;
  assign keep_mask = wr_hit ? wr_keep : '1;
  assign pend_d    = (pend_q & keep_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  mpb_lsb_index #(.REG_W(REG_W)) u_index (
    .vec (pend_q),
    .idx (idx)
  );

  // R7: a set bit survives any concurrent clear
  p_set_survives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> pend_q[$past(set_bit)]);

  // R6: a write alone only keeps masked bits
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !set_hit) |=> (pend_q == ($past(pend_q) & $past(wr_keep))));

  // R10: idle register holds
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !set_hit) |=> $stable(pend_q));

  // R8: index points at a set bit with nothing below it
  always_comb begin
    if (rst_n && pend_q != '0) begin
      p_index_lowest_r8: assert (pend_q[idx[BIT_W-1:0]] && idx < IDX_W'(REG_W) &&
        ((pend_q & ((REG_W'(1) << idx[BIT_W-1:0]) - REG_W'(1))) == '0));
    end
  end
endmodule

// File: rtl/msg_pend_bank.sv
module msg_pend_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  localparam int RSEL_W  = $clog2(NUM_REGS),
  localparam int BIT_W   = $clog2(REG_W),
  localparam int PN_W    = RSEL_W + BIT_W,
  localparam int NP_W    = RSEL_W + 1,
  localparam int ADDR_W  = RSEL_W + 1,
  localparam int IDX_W   = BIT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              ev_valid,
  input  logic              ev_is_tx,
  input  logic [PN_W-1:0]   ev_pnum,
  input  logic [NP_W-1:0]   ev_rx_np,
  input  logic [NP_W-1:0]   ev_tx_np,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  sw_rdata
);
  import mpb_pkg::*;

  logic [RSEL_W-1:0] loc_reg;
  logic [BIT_W-1:0]  loc_bit;
  logic [NUM_REGS-1:0] set_hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic [REG_W-1:0]    pend_q [NUM_REGS];
  logic [IDX_W-1:0]    idx_q  [NUM_REGS];
  bank_sel_e           rd_bank;
  logic [RSEL_W-1:0]   rd_reg;

  mpb_locate #(.RSEL_W(RSEL_W), .BIT_W(BIT_W)) u_locate (
    .mode    (mode),
    .is_tx   (ev_is_tx),
    .pnum    (ev_pnum),
    .rx_np   (ev_rx_np),
    .tx_np   (ev_tx_np),
    .reg_sel (loc_reg),
    .bit_pos (loc_bit)
  );

  assign rd_bank = bank_sel_e'(sw_addr[ADDR_W-1]);
  assign rd_reg  = sw_addr[RSEL_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign set_hit[g] = ev_valid && (loc_reg == RSEL_W'(g));
    assign wr_hit[g]  = sw_wr && (rd_bank == BANK_PEND) && (rd_reg == RSEL_W'(g));

    mpb_pend_reg #(.REG_W(REG_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_hit (set_hit[g]),
      .set_bit (loc_bit),
      .wr_hit  (wr_hit[g]),
      .wr_keep (sw_wdata),
      .pend_q  (pend_q[g]),
      .idx     (idx_q[g])
    );
  end

  always_comb begin
    if (rd_bank == BANK_INDEX) sw_rdata = REG_W'(idx_q[rd_reg]);
    else                       sw_rdata = pend_q[rd_reg];
  end

  // R2: one event reaches at most one register
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_hit) && (ev_valid == (set_hit != '0)));

  // R9: index-bank writes reach no register
  p_index_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && rd_bank == BANK_INDEX) |-> (wr_hit == '0));

  // R10: no set without a valid strobe
  p_no_spurious_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (set_hit == '0));
endmodule

// File: tb/msg_pend_bank_tb.sv
`timescale 1ns/10ps
module msg_pend_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'h0;
  logic        ev_valid = 1'b0;
  logic        ev_is_tx = 1'b0;
  logic [7:0]  ev_pnum = 8'h0;
  logic [3:0]  ev_rx_np = 4'h0;
  logic [3:0]  ev_tx_np = 4'h0;
  logic        sw_wr = 1'b0;
  logic [3:0]  sw_addr = 4'h0;
  logic [31:0] sw_wdata = 32'h0;
  logic [31:0] sw_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [8];
  bit done = 0;

  always #2.5 clk = ~clk;

  msg_pend_bank u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ev_valid(ev_valid),
    .ev_is_tx(ev_is_tx), .ev_pnum(ev_pnum), .ev_rx_np(ev_rx_np),
    .ev_tx_np(ev_tx_np), .sw_wr(sw_wr), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  function automatic int ref_reg(logic [3:0] m, logic tx, logic [7:0] pn,
                                 logic [3:0] rxn, logic [3:0] txn);
    if (m == 4'b1111) return tx ? int'(txn) / 2 : int'(rxn) / 2;
    return int'(pn) / 32;
  endfunction

  function automatic int ref_bit(logic [3:0] m, logic tx, logic [7:0] pn,
                                 logic [3:0] rxn, logic [3:0] txn);
    if (m == 4'b1111) return (tx ? int'(txn) % 2 : int'(rxn) % 2) * 16 + int'(pn) % 16;
    return int'(pn) % 32;
  endfunction

  function automatic int ref_idx(logic [31:0] v);
    int n;
    if (v == 0) return 32;
    n = 0;
    while (v[0] == 1'b0) begin v = v >> 1; n++; end
    return n;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic verify_all(string tag);
    for (int k = 0; k < 8; k++) begin
      sw_addr = 4'(k); #0.1;
      check(tag, sw_rdata, model[k]);
      sw_addr = 4'(8 + k); #0.1;
      check("R8", sw_rdata, 32'(ref_idx(model[k])));
    end
  endtask

  // one clock: optional event and optional write, then model update and readback
  task automatic step(string tag, logic v, logic [3:0] m, logic tx, logic [7:0] pn,
                      logic [3:0] rxn, logic [3:0] txn,
                      logic w, logic [3:0] a, logic [31:0] d);
    int r, b;
    @(negedge clk);
    mode = m; ev_valid = v; ev_is_tx = tx; ev_pnum = pn;
    ev_rx_np = rxn; ev_tx_np = txn; sw_wr = w; sw_addr = a; sw_wdata = d;
    @(posedge clk);
    if (w && !a[3]) model[a[2:0]] = model[a[2:0]] & d;
    if (v) begin
      r = ref_reg(m, tx, pn, rxn, txn);
      b = ref_bit(m, tx, pn, rxn, txn);
      model[r][b] = 1'b1;
    end
    #0.2;
    ev_valid = 1'b0; sw_wr = 1'b0;
    verify_all(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    verify_all("R1");

    // R2 default placement: pnum 0xFF -> reg 7 bit 31
    step("R2", 1, 4'h0, 0, 8'hFF, 4'h0, 4'h0, 0, 4'h0, 32'h0);
    // R3 split tx: tx_np 1011, pnum 0x05 -> reg 5 bit 21
    step("R3", 1, 4'hF, 1, 8'h05, 4'h2, 4'hB, 0, 4'h0, 32'h0);
    // R4 split rx: rx_np 0010 -> reg 1 bit 5
    step("R4", 1, 4'hF, 0, 8'h05, 4'h2, 4'hB, 0, 4'h0, 32'h0);
    // R5 other mode acts default: pnum 0x43 -> reg 2 bit 3
    step("R5", 1, 4'h5, 1, 8'h43, 4'hF, 4'hF, 0, 4'h0, 32'h0);
    // R9 write to index address of reg 7 leaves it
    step("R9", 0, 4'h0, 0, 8'h00, 4'h0, 4'h0, 1, 4'hF, 32'h0);
    // R6 write zero clears reg 7 bit 31, keep mask on reg 5
    step("R6", 0, 4'h0, 0, 8'h00, 4'h0, 4'h0, 1, 4'h7, 32'h7FFF_FFFF);
    step("R6", 0, 4'h0, 0, 8'h00, 4'h0, 4'h0, 1, 4'h5, 32'hFFFF_FFFF);
    // R7 set reg 2 bit 9 while clearing whole reg 2 -> only bit 9
    step("R7", 1, 4'h0, 0, 8'h49, 4'h0, 4'h0, 1, 4'h2, 32'h0);
    // R7 set and clear of the same bit: set wins
    step("R7", 1, 4'h0, 0, 8'h49, 4'h0, 4'h0, 1, 4'h2, 32'hFFFF_FDFF);
    // R10 idle cycle
    step("R10", 0, 4'hF, 1, 8'hFF, 4'hF, 4'hF, 0, 4'h0, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] m, rn, tn, a;
      logic [7:0] pn;
      logic tx, v, w;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 2);
      m  = (sel == 0) ? 4'h0 : (sel == 1) ? 4'hF : 4'($urandom);
      tx = 1'($urandom); pn = 8'($urandom); rn = 4'($urandom); tn = 4'($urandom);
      v  = ($urandom_range(0, 3) != 0);
      w  = ($urandom_range(0, 2) == 0);
      a  = 4'($urandom);
      if ($urandom_range(0, 1) == 1)
        a = {1'b0, 3'(ref_reg(m, tx, pn, rn, tn))};
      d  = $urandom | $urandom;
      step("R7", v, m, tx, pn, rn, tn, w, a, d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule